// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block sits between a simple internal request port and an external byte-wide asynchronous static RAM with 19 address bits. A client presents a request with a valid/ready handshake, a write select, an address and write data. The controller then runs the memory strobes (active-low chip select, write enable and output enable) through a fixed sequence. For a read it returns the captured byte, and for either kind of access it pulses a completion strobe.

The length of each phase is taken from the memory's nanosecond limits for the chosen speed grade. At elaboration each limit is turned into a clock count by ceiling division by the clock period parameter. The data bus is split into a drive value, a drive enable and a sampled input, so the pad ring can build the tri-state buffer. Output enable is never low while write enable is low, so the controller and the memory never drive the bus at the same time. After a read, a quiet interval lets the memory release the bus before anything else can happen.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is low and on the first cycle after it, chip select, write enable and output enable are high, the data drive enable is low, `req_ready` is high and `rsp_done` is low.
- R2: `req_ready` goes low on the edge that accepts a request (`req_valid` and `req_ready` both high). It stays low until the edge that raises `rsp_done`, and on that edge it rises again. `rsp_done` is high for exactly one cycle per request.
- R3: A write (`req_write`=1) first holds chip select low with write enable high for one cycle. Write enable is then low for WP cycles, where WP is the largest of ceil(tWP/T), ceil(tDS/T), ceil(tAW/T)-1 and ceil(tWC/T)-1 and T is `CLK_NS`. `rsp_done` rises 1+WP cycles after acceptance.
- R4: `mem_dq_oe` is high only while write enable is low, and during that time `mem_dq_o` equals the request's write data. The drive is released on the same edge on which write enable rises.
- R5: Whenever write enable is low, chip select is low and output enable is high.
- R6: A read (`req_write`=0) holds chip select and output enable low together for RD cycles, where RD is the largest of ceil(tRC/T), ceil(tAA/T), ceil(tCO/T) and ceil(tOE/T). Both rise on the edge that captures `mem_dq_i` into `rsp_rdata`.
- R7: After a read, all strobes stay high and the bus stays undriven for HZ = ceil(tOHZ/T) cycles. `rsp_done` then rises, which is RD+HZ cycles after acceptance.
- R8: While chip select is low, `mem_addr` equals the accepted request address and does not change.
- R9: `GRADE`=0 uses 15/12/12/7/15/15/15/7/7 ns for tWC/tWP/tAW/tDS/tRC/tAA/tCO/tOE/tOHZ. `GRADE`=1 uses 20/14/14/9/20/20/20/9/9 ns. With T=5 ns, grade 0 completes writes in 4 cycles and reads in 5 cycles. Grade 1 completes writes in 4 cycles and reads in 6 cycles, with a 4-cycle output-enable window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, period `CLK_NS` |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address of the request |
| req_wdata | input | 8 | Data to write |
| rsp_rdata | output | 8 | Byte captured by the last read |
| rsp_done | output | 1 | One-cycle completion strobe |
| mem_addr | output | 19 | Address to the memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_o | output | 8 | Value to drive onto the data bus |
| mem_dq_oe | output | 1 | Data bus drive enable for the pad |
| mem_dq_i | input | 8 | Data bus as seen by the pad input |

## Verification
Take the accepting edge as cycle 0. For a write, chip select falls on cycle 0, write enable is low on cycles 1 to WP, and the completion strobe arrives on cycle 1+WP. For a read, output enable is low on cycles 0 to RD-1, the data is captured at edge RD, and completion arrives at edge RD+HZ. The monitor samples on the falling clock edge and counts falling edges from the one where it first sees the request offered, so every latency, pulse length and capture value is compared in the exact cycle these counts predict. Two instances with different speed grades get the same requests and are compared against their own expected counts.

// File: rtl/asram_pkg.sv
// Shared types and elaboration-time helpers for the static RAM controller.
// Assumes all timing arguments are positive integers of nanoseconds.
package asram_pkg;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,   // waiting for a request
        S_WSET = 3'd1,   // chip select low, address settling
        S_WPUL = 3'd2,   // write enable low, data driven
        S_RACC = 3'd3,   // chip select and output enable low
        S_RHZ  = 3'd4    // read done, waiting for bus release
    } seq_st_e;

    // Ceiling of a/b for positive integers.
    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    // Larger of two integers.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_timer.sv
// Loadable down-counter that measures the length of a sequencer phase.
// Assumes the loaded value is the phase length minus one; "expired" is high
// once the count has reached zero.
module asram_timer #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt_q;

    // Load a new phase length or count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Phase is over once the counter sits at zero.
    always_comb begin
        expired = (cnt_q == '0);
    end

endmodule

// File: rtl/asram_seq.sv
// Access sequencer: walks idle -> (write setup -> write pulse) or
// (read access -> bus release) -> idle, loading the phase timer on entry
// to each timed phase. Assumes every phase length is at least one cycle.
module asram_seq
    import asram_pkg::*;
#(
    parameter int CW     = 2,
    parameter int WP_CYC = 2,
    parameter int RD_CYC = 2,
    parameter int HZ_CYC = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          tmr_expired,
    output seq_st_e       st_q,
    output seq_st_e       st_d,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val
);

    localparam logic [CW-1:0] WP_LD = CW'(WP_CYC - 1);
    localparam logic [CW-1:0] RD_LD = CW'(RD_CYC - 1);
    localparam logic [CW-1:0] HZ_LD = CW'(HZ_CYC - 1);

    // Next-state and timer-load decision for the current phase.
    always_comb begin
        st_d     = st_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (st_q)
            S_IDLE: begin
                if (req_valid) begin
                    if (req_write) begin
                        st_d = S_WSET;
                    end else begin
                        st_d     = S_RACC;
                        tmr_load = 1'b1;
                        tmr_val  = RD_LD;
                    end
                end
            end
            S_WSET: begin
                st_d     = S_WPUL;
                tmr_load = 1'b1;
                tmr_val  = WP_LD;
            end
            S_WPUL: begin
                if (tmr_expired) begin
                    st_d = S_IDLE;
                end
            end
            S_RACC: begin
                if (tmr_expired) begin
                    st_d     = S_RHZ;
                    tmr_load = 1'b1;
                    tmr_val  = HZ_LD;
                end
            end
            S_RHZ: begin
                if (tmr_expired) begin
                    st_d = S_IDLE;
                end
            end
            default: st_d = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= S_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/asram_pins.sv
// Registered memory-side pins and response outputs. All strobes are decoded
// from the sequencer's next state, so each pin changes on the same edge as
// the phase it belongs to. Assumes the address and data are stable in the
// request cycle.
module asram_pins
    import asram_pkg::*;
#(
    parameter int AW = 19,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  seq_st_e       st_q,
    input  seq_st_e       st_d,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] mem_dq_i,
    output logic [AW-1:0] mem_addr,
    output logic          mem_cs_n,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic [DW-1:0] mem_dq_o,
    output logic          mem_dq_oe,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_done
);

    logic accept;
    logic capture;
    logic finish;

    // Decode the edges on which a request is taken, read data is sampled
    // and an access completes.
    always_comb begin
        accept  = (st_q == S_IDLE) && (st_d != S_IDLE);
        capture = (st_q == S_RACC) && (st_d == S_RHZ);
        finish  = (st_q != S_IDLE) && (st_d == S_IDLE);
    end

    // Latch the address and write data once per accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            mem_dq_o <= '0;
        end else if (accept) begin
            mem_addr <= req_addr;
            mem_dq_o <= req_wdata;
        end
    end

    // Drive the strobes and the bus enable from the phase being entered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_cs_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
        end else begin
            mem_cs_n  <= !((st_d == S_WSET) || (st_d == S_WPUL) || (st_d == S_RACC));
            mem_we_n  <= (st_d != S_WPUL);
            mem_oe_n  <= (st_d != S_RACC);
            mem_dq_oe <= (st_d == S_WPUL);
        end
    end

    // Sample the bus at the end of the read window and flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
            rsp_done  <= 1'b0;
        end else begin
            if (capture) begin
                rsp_rdata <= mem_dq_i;
            end
            rsp_done <= finish;
        end
    end

endmodule

// File: rtl/asram_ctrl.sv
// Top of the asynchronous static RAM controller. Converts the speed grade's
// nanosecond limits to cycle counts at elaboration and ties the sequencer,
// phase timer and pin registers together. Assumes one request at a time
// and a memory whose data pins are wired through an external tri-state pad
// controlled by mem_dq_oe.
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int CLK_NS = 10,
    parameter int GRADE  = 0,
    parameter int AW     = 19,
    parameter int DW     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_done,
    output logic [AW-1:0] mem_addr,
    output logic          mem_cs_n,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic [DW-1:0] mem_dq_o,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_i
);

    // Speed-grade limits in nanoseconds.
    localparam int T_WC  = (GRADE != 0) ? 20 : 15;
    localparam int T_WP  = (GRADE != 0) ? 14 : 12;
    localparam int T_AW  = (GRADE != 0) ? 14 : 12;
    localparam int T_DS  = (GRADE != 0) ? 9  : 7;
    localparam int T_RC  = (GRADE != 0) ? 20 : 15;
    localparam int T_AA  = (GRADE != 0) ? 20 : 15;
    localparam int T_CO  = (GRADE != 0) ? 20 : 15;
    localparam int T_OE  = (GRADE != 0) ? 9  : 7;
    localparam int T_OHZ = (GRADE != 0) ? 9  : 7;

    // Phase lengths in cycles; the setup cycle counts towards tAW and tWC.
    localparam int WP_CYC = imax(imax(cdiv(T_WP, CLK_NS), cdiv(T_DS, CLK_NS)),
                                 imax(imax(cdiv(T_AW, CLK_NS) - 1, cdiv(T_WC, CLK_NS) - 1), 1));
    localparam int RD_CYC = imax(imax(cdiv(T_RC, CLK_NS), cdiv(T_AA, CLK_NS)),
                                 imax(cdiv(T_CO, CLK_NS), cdiv(T_OE, CLK_NS)));
    localparam int HZ_CYC = imax(cdiv(T_OHZ, CLK_NS), 1);
    localparam int C_MAX  = imax(imax(WP_CYC, RD_CYC), HZ_CYC);
    localparam int CW     = (C_MAX < 2) ? 1 : $clog2(C_MAX);

    seq_st_e       st_q;
    seq_st_e       st_d;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_expired;

    asram_seq #(
        .CW     (CW),
        .WP_CYC (WP_CYC),
        .RD_CYC (RD_CYC),
        .HZ_CYC (HZ_CYC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .tmr_expired (tmr_expired),
        .st_q        (st_q),
        .st_d        (st_d),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val)
    );

    asram_timer #(
        .CW (CW)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    asram_pins #(
        .AW (AW),
        .DW (DW)
    ) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .st_q      (st_q),
        .st_d      (st_d),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mem_dq_i  (mem_dq_i),
        .mem_addr  (mem_addr),
        .mem_cs_n  (mem_cs_n),
        .mem_we_n  (mem_we_n),
        .mem_oe_n  (mem_oe_n),
        .mem_dq_o  (mem_dq_o),
        .mem_dq_oe (mem_dq_oe),
        .rsp_rdata (rsp_rdata),
        .rsp_done  (rsp_done)
    );

    // The controller is ready only while idle.
    always_comb begin
        req_ready = (st_q == S_IDLE);
    end

endmodule

// File: rtl/asram_chk.sv
// Protocol checker for asram_ctrl, attached by bind. It watches only the
// top-level ports and measures strobe widths with its own run counters.
module asram_chk #(
    parameter int AW     = 19,
    parameter int WP_CYC = 2,
    parameter int RD_CYC = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          rsp_done,
    input logic [AW-1:0] mem_addr,
    input logic          mem_cs_n,
    input logic          mem_we_n,
    input logic          mem_oe_n,
    input logic          mem_dq_oe
);

    logic [15:0] we_run;
    logic [15:0] oe_run;

    // Count consecutive cycles with each strobe low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_run <= '0;
            oe_run <= '0;
        end else begin
            we_run <= mem_we_n ? 16'd0 : we_run + 16'd1;
            oe_run <= mem_oe_n ? 16'd0 : oe_run + 16'd1;
        end
    end

    assert_ready_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_done_with_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> req_ready);

    assert_cs_before_we_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> $past(!mem_cs_n));

    assert_we_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_run == 16'(WP_CYC)));

    assert_drive_in_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && !mem_cs_n));

    assert_release_with_we_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> !mem_dq_oe);

    assert_no_contention_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && !mem_cs_n));

    assert_oe_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> ((oe_run == 16'(RD_CYC)) && mem_cs_n));

    assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

endmodule

bind asram_ctrl asram_chk #(
    .AW     (AW),
    .WP_CYC (WP_CYC),
    .RD_CYC (RD_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sim_asram_ctrl.sv
`timescale 1ns/1ps
// Scoreboard bench: two controllers (grade 0 and grade 1, 5 ns clock) take
// the same requests; each has its own memory model and monitor.
module sim_asram_ctrl;

    typedef struct {
        bit          wr;
        logic [18:0] a;
        logic [7:0]  d;
    } item_t;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n     = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [18:0] req_addr  = '0;
    logic [7:0]  req_wdata = '0;

    logic        rdy0, done0, cs0, we0, oe0, dqoe0;
    logic [7:0]  rd0, dqo0, dqi0;
    logic [18:0] ad0;
    logic        rdy1, done1, cs1, we1, oe1, dqoe1;
    logic [7:0]  rd1, dqo1, dqi1;
    logic [18:0] ad1;

    int n_chk = 0;
    int n_bad = 0;

    asram_ctrl #(.CLK_NS(5), .GRADE(0)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy0),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rd0), .rsp_done(done0), .mem_addr(ad0), .mem_cs_n(cs0),
        .mem_we_n(we0), .mem_oe_n(oe0), .mem_dq_o(dqo0), .mem_dq_oe(dqoe0),
        .mem_dq_i(dqi0)
    );

    asram_ctrl #(.CLK_NS(5), .GRADE(1)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy1),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rd1), .rsp_done(done1), .mem_addr(ad1), .mem_cs_n(cs1),
        .mem_we_n(we1), .mem_oe_n(oe1), .mem_dq_o(dqo1), .mem_dq_oe(dqoe1),
        .mem_dq_i(dqi1)
    );

    // Memory models indexed by the low six address bits.
    logic [7:0] mem0 [64];
    logic [7:0] mem1 [64];
    logic [7:0] shadow [64];

    assign dqi0 = mem0[ad0[5:0]];
    assign dqi1 = mem1[ad1[5:0]];

    always @(negedge clk) begin
        if (!cs0 && !we0 && dqoe0) mem0[ad0[5:0]] <= dqo0;
        if (!cs1 && !we1 && dqoe1) mem1[ad1[5:0]] <= dqo1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    item_t q0[$];
    item_t q1[$];
    int    dn0 = 0;
    int    dn1 = 0;

    // Driver: push the expected item, offer the request for one cycle,
    // then wait until both monitors have retired it.
    task automatic issue(input bit wr, input logic [18:0] a, input logic [7:0] d);
        item_t it;
        int t0;
        int t1;
        t0 = dn0 + 1;
        t1 = dn1 + 1;
        it.wr = wr;
        it.a  = a;
        it.d  = wr ? d : shadow[a[5:0]];
        if (wr) shadow[a[5:0]] = d;
        q0.push_back(it);
        q1.push_back(it);
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk); #1;
        req_valid = 1'b0;
        while (dn0 < t0 || dn1 < t1) @(negedge clk);
    endtask

    // Monitor for the grade-0 instance.
    bit    act0 = 0;
    int    c0, wr0, or0;
    item_t cur0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!act0) begin
                if (req_valid && rdy0) begin
                    act0 = 1; c0 = -1; wr0 = 0; or0 = 0;
                    chk(!done0, "R2 done lasts one cycle", 32'(done0), 0);
                end
            end else begin
                cur0 = q0[0];
                c0++;
                if (!we0) begin
                    wr0++;
                    chk(!cs0 && oe0, "R5 write strobes", {30'd0, cs0, oe0}, 32'd1);
                    chk(dqoe0 && dqo0 == cur0.d, "R4 write data driven", {23'd0, dqoe0, dqo0}, {24'd1, cur0.d});
                end else if (wr0 != 0) begin
                    chk(wr0 == 3, "R3 write pulse width", 32'(wr0), 32'd3);
                    chk(!dqoe0, "R4 drive released with we", 32'(dqoe0), 0);
                    wr0 = 0;
                end
                if (!oe0) begin
                    or0++;
                end else if (or0 != 0) begin
                    chk(or0 == 3, "R6 read window width", 32'(or0), 32'd3);
                    chk(cs0, "R6 cs rises with oe", 32'(cs0), 32'd1);
                    or0 = 0;
                end
                if (!cs0) chk(ad0 == cur0.a, "R8 address held", 32'(ad0), 32'(cur0.a));
                if (cur0.wr && c0 == 0)
                    chk(!cs0 && we0 && !dqoe0, "R3 setup cycle", {29'd0, cs0, we0, dqoe0}, 32'd2);
                if (!cur0.wr && c0 >= 3 && !done0)
                    chk(cs0 && oe0 && we0 && !dqoe0, "R7 quiet after read", {28'd0, cs0, oe0, we0, dqoe0}, 32'he);
                if (done0) begin
                    if (cur0.wr) chk(c0 == 4, "R3 write latency", 32'(c0), 32'd4);
                    else begin
                        chk(c0 == 5, "R7 read latency", 32'(c0), 32'd5);
                        chk(rd0 == cur0.d, "R6 read data", 32'(rd0), 32'(cur0.d));
                    end
                    chk(rdy0, "R2 ready with done", 32'(rdy0), 32'd1);
                    void'(q0.pop_front());
                    act0 = 0;
                    dn0++;
                end else begin
                    chk(!rdy0, "R2 busy not ready", 32'(rdy0), 0);
                end
            end
        end
    end

    // Monitor for the grade-1 instance.
    bit    act1 = 0;
    int    c1, wr1, or1;
    item_t cur1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!act1) begin
                if (req_valid && rdy1) begin
                    act1 = 1; c1 = -1; wr1 = 0; or1 = 0;
                end
            end else begin
                cur1 = q1[0];
                c1++;
                if (!we1) wr1++;
                else if (wr1 != 0) begin
                    chk(wr1 == 3, "R9 grade1 write pulse", 32'(wr1), 32'd3);
                    wr1 = 0;
                end
                if (!oe1) or1++;
                else if (or1 != 0) begin
                    chk(or1 == 4, "R9 grade1 read window", 32'(or1), 32'd4);
                    or1 = 0;
                end
                if (done1) begin
                    if (cur1.wr) chk(c1 == 4, "R9 grade1 write latency", 32'(c1), 32'd4);
                    else begin
                        chk(c1 == 6, "R9 grade1 read latency", 32'(c1), 32'd6);
                        chk(rd1 == cur1.d, "R9 grade1 read data", 32'(rd1), 32'(cur1.d));
                    end
                    void'(q1.pop_front());
                    act1 = 0;
                    dn1++;
                end
            end
        end
    end

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", dn0, q0.size() + dn0);
        summary();
    end

    // Stimulus.
    initial begin
        for (int i = 0; i < 64; i++) begin
            mem0[i]   = 8'(i) ^ 8'h6c;
            mem1[i]   = 8'(i) ^ 8'h6c;
            shadow[i] = 8'(i) ^ 8'h6c;
        end
        repeat (4) @(negedge clk);
        // R1: pins inactive during reset.
        chk(cs0 && we0 && oe0 && !dqoe0, "R1 strobes in reset", {28'd0, cs0, we0, oe0, dqoe0}, 32'he);
        chk(rdy0 && !done0, "R1 handshake in reset", {30'd0, rdy0, done0}, 32'd2);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs0 && we0 && oe0 && !dqoe0 && rdy0 && !done0, "R1 first cycle after reset",
            {26'd0, cs0, we0, oe0, dqoe0, rdy0, done0}, 32'h3a);

        issue(1'b1, 19'h00005, 8'ha5);
        issue(1'b1, 19'h7ffc1, 8'h3c);
        issue(1'b1, 19'h40012, 8'hff);
        issue(1'b0, 19'h00005, 8'h00);
        issue(1'b0, 19'h7ffc1, 8'h00);
        issue(1'b0, 19'h1003f, 8'h00);   // never written: initial content
        issue(1'b1, 19'h0002a, 8'h00);
        issue(1'b0, 19'h0002a, 8'h00);
        issue(1'b0, 19'h40012, 8'h00);
        issue(1'b1, 19'h00033, 8'h5a);
        issue(1'b0, 19'h00033, 8'h00);   // read right after write, same address
        issue(1'b1, 19'h00033, 8'h81);   // write right after read
        issue(1'b0, 19'h00033, 8'h00);
        repeat (3) @(negedge clk);
        chk(!done0 && rdy0, "R2 idle after last request", {30'd0, done0, rdy0}, 32'd1);
        summary();
    end

endmodule